// File: doc/BRIEF.md
# Linked-List Descriptor Fetcher

This block sequences one physical channel of a memory-to-memory or peripheral transfer engine through a chain of descriptors kept in memory. Software places the first descriptor's fields straight into the channel's registers and then writes the control word with its enable bit set. The channel launches the data mover with those fields. When the mover reports that the node is finished, the block inspects the node's link word. If chaining is on, it reads the next 32-byte descriptor over a simple one-word-at-a-time memory read port and launches again. If chaining is off, it ends the chain.

A node can ask for an event when it completes. The end of a chain raises its own event. If the last node links back to the head, the channel loops until software drops the enable bit. Dropping the enable bit at any other time pauses the channel, and setting it again resumes it from the same point. The current link word and the remaining transfer count are visible as outputs. The mover reports its progress in fixed-size steps.

Top module: `lldf_top`

## Requirements
- R1: After reset, busy, mv_start, mem_req, node_irq and chain_irq are low, and cur_link and cur_count are zero.
- R2: Host writes use reg_sel codes 0 = link, 1 = count, 2 = source, 3 = destination and 4 = control. Control bit 0 is the enable bit. While the channel is idle, a control write with bit 0 set raises mv_start for one cycle in the cycle after the write. mv_src, mv_dst and cur_count then carry the values that were written, and busy is high.
- R3: While a chain is active, host writes to link, count, source and destination are ignored. A control write changes only bit 0.
- R4: When a node finishes and bit 1 of its link word is set, eight 4-byte reads go out one at a time at ascending addresses. The first address is the link word with its low 5 bits cleared. Word 0 loads the link, word 4 loads the count, word 5 the source, word 6 the destination and word 7 control bits 31:1. Words 1 to 3 are discarded. The next mv_start then carries the new fields.
- R5: When a node finishes and bit 1 of its link word is clear (a zero word included), chain_irq pulses for one cycle. No read is issued, and busy falls and stays low.
- R6: node_irq pulses once at the end of each node whose control bit 1 is set, and never at the end of a node where that bit is clear.
- R7: A node whose link word points back to a chained descriptor loops without end, raising no chain_irq, until the enable bit is cleared.
- R8: Clearing the enable bit mid-chain drops busy and stops any new mv_start or memory read. Setting it again resumes the chain where it stopped.
- R9: Each mv_step pulse lowers cur_count by STEP_BYTES, saturating at zero.
- R10: Bit 0 of a fetched control word does not change the enable bit.
- R11: cur_link shows the link word of the node in flight, and reads zero once a chain with a zero link has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select |
| reg_wdata | input | 32 | Host write data |
| mem_req | output | 1 | Descriptor word read request, one cycle |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the request |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | Launch pulse to the data mover |
| mv_src | output | 32 | Source address of the current node |
| mv_dst | output | 32 | Destination address of the current node |
| mv_ctrl | output | 32 | Control word of the current node |
| mv_done | input | 1 | Mover reports that the node is finished |
| mv_step | input | 1 | Mover moved STEP_BYTES bytes |
| node_irq | output | 1 | Per-node completion event |
| chain_irq | output | 1 | Chain completion event |
| busy | output | 1 | Channel enabled and in a chain |
| cur_link | output | 32 | Current link word |
| cur_count | output | CNT_W | Remaining count |

## Verification
The bench targets link words that carry stray low bits. If the block masked the wrong bits, the read addresses would drift off the descriptor. It also uses a fetched control word with its enable bit clear, which a careless load would turn into a silent stall after the first fetch.

Host writes are issued mid-chain. If the block let them through, the next launch would carry corrupt addresses, or a node would gain an unwanted event. The bench pauses the channel while a node is running, so that the fetch becomes due inside the pause. If the pause were only partial, a read would leak out, or the chain would drop its place on resume.

A self-linked node runs several laps and is then stopped. The bench checks that it raises no chain event. Count steps run past zero to catch wraparound.

// File: rtl/lldf_pkg.sv
package lldf_pkg;
  localparam int DESC_WORDS = 8;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int ALIGN_BITS = $clog2(DESC_WORDS * 4);

  localparam int W_LINK  = 0;
  localparam int W_COUNT = 4;
  localparam int W_SRC   = 5;
  localparam int W_DST   = 6;
  localparam int W_CTRL  = 7;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_NODE_BIT  = 1;
  localparam int LINK_CHAIN_BIT = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_MOVE, ST_FETCH} lldf_state_t;

  typedef enum logic [2:0] {
    SEL_LINK  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_SRC   = 3'd2,
    SEL_DST   = 3'd3,
    SEL_CTRL  = 3'd4
  } lldf_sel_t;

  // Aligned descriptor address from a link word.
  function automatic logic [31:0] desc_base(input logic [31:0] link);
    return link & ~(32'((1 << ALIGN_BITS) - 1));
  endfunction

  // Byte address of word idx inside a descriptor.
  function automatic logic [31:0] word_addr(input logic [31:0] base,
                                            input logic [WIDX_W-1:0] idx);
    return base + (32'(idx) << 2);
  endfunction

  function automatic logic link_continues(input logic [31:0] link);
    return link[LINK_CHAIN_BIT];
  endfunction
endpackage

// File: rtl/lldf_regs.sv
module lldf_regs
  import lldf_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int STEP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [31:0]       host_wdata,
  input  logic              idle,
  input  logic              fw_we,
  input  logic [WIDX_W-1:0] fw_idx,
  input  logic [31:0]       fw_data,
  input  logic              step,
  input  logic              chain_end,
  output logic [31:0]       link,
  output logic [CNT_W-1:0]  cnt,
  output logic [31:0]       src,
  output logic [31:0]       dst,
  output logic [31:0]       ctrl
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link <= '0;
      cnt  <= '0;
      src  <= '0;
      dst  <= '0;
      ctrl <= '0;
    end else begin
      if (step) cnt <= (cnt > STEP_V) ? cnt - STEP_V : '0;
      if (host_we && idle) begin
        case (host_sel)
          SEL_LINK:  link <= host_wdata;
          SEL_COUNT: cnt  <= host_wdata[CNT_W-1:0];
          SEL_SRC:   src  <= host_wdata;
          SEL_DST:   dst  <= host_wdata;
          SEL_CTRL:  ctrl[31:1] <= host_wdata[31:1];
          default: ;
        endcase
      end
      if (host_we && host_sel == SEL_CTRL) ctrl[CTRL_EN_BIT] <= host_wdata[CTRL_EN_BIT];
      if (fw_we) begin
        case (int'(fw_idx))
          W_LINK:  link <= fw_data;
          W_COUNT: cnt  <= fw_data[CNT_W-1:0];
          W_SRC:   src  <= fw_data;
          W_DST:   dst  <= fw_data;
          W_CTRL:  ctrl[31:1] <= fw_data[31:1];
          default: ;
        endcase
      end
      if (chain_end) ctrl[CTRL_EN_BIT] <= 1'b0;
    end
  end

  // R3
  frozen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !fw_we) |=> $stable(src));
endmodule

// File: rtl/lldf_fetch.sv
module lldf_fetch
  import lldf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_fetch,
  input  logic [31:0]       link,
  input  logic              allow,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic              fw_we,
  output logic [WIDX_W-1:0] fw_idx,
  output logic [31:0]       fw_data,
  output logic              fetch_last
);
  logic [31:0]       base;
  logic [WIDX_W-1:0] idx;
  logic              outstanding;

  assign mem_req    = allow && !outstanding;
  assign mem_addr   = word_addr(base, idx);
  assign fw_we      = mem_rvalid && outstanding;
  assign fw_idx     = idx;
  assign fw_data    = mem_rdata;
  assign fetch_last = fw_we && (idx == WIDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base        <= '0;
      idx         <= '0;
      outstanding <= 1'b0;
    end else if (begin_fetch) begin
      base        <= desc_base(link);
      idx         <= '0;
      outstanding <= 1'b0;
    end else begin
      if (mem_req) outstanding <= 1'b1;
      if (fw_we) begin
        outstanding <= 1'b0;
        idx         <= idx + 1'b1;
      end
    end
  end

  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: rtl/lldf_seq.sv
module lldf_seq
  import lldf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic        host_en_bit,
  input  logic        enable,
  input  logic        node_flag,
  input  logic [31:0] link,
  input  logic        mv_done,
  input  logic        fetch_last,
  output lldf_state_t state,
  output logic        mv_start,
  output logic        begin_fetch,
  output logic        chain_end,
  output logic        node_irq,
  output logic        chain_irq,
  output logic        busy,
  output logic        idle
);
  logic go, move_done;

  assign go          = host_we && (host_sel == SEL_CTRL) && host_en_bit && (state == ST_IDLE);
  assign move_done   = (state == ST_MOVE) && mv_done;
  assign begin_fetch = move_done && link_continues(link);
  assign chain_end   = move_done && !link_continues(link);
  assign mv_start    = (state == ST_LAUNCH) && enable;
  assign busy        = enable && (state != ST_IDLE);
  assign idle        = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      node_irq  <= 1'b0;
      chain_irq <= 1'b0;
    end else begin
      node_irq  <= move_done && node_flag;
      chain_irq <= chain_end;
      case (state)
        ST_IDLE:   if (go) state <= ST_LAUNCH;
        ST_LAUNCH: if (enable) state <= ST_MOVE;
        ST_MOVE:   if (move_done) state <= link_continues(link) ? ST_FETCH : ST_IDLE;
        ST_FETCH:  if (fetch_last) state <= ST_LAUNCH;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);
  // R5
  chain_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq |-> ($past(mv_done) && !busy));
  // R6
  node_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_irq |-> $past(mv_done));
  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAUNCH && !enable) |=> (state == ST_LAUNCH));
endmodule

// File: rtl/lldf_top.sv
module lldf_top
  import lldf_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int STEP_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             mv_start,
  output logic [31:0]      mv_src,
  output logic [31:0]      mv_dst,
  output logic [31:0]      mv_ctrl,
  input  logic             mv_done,
  input  logic             mv_step,
  output logic             node_irq,
  output logic             chain_irq,
  output logic             busy,
  output logic [31:0]      cur_link,
  output logic [CNT_W-1:0] cur_count
);
  lldf_state_t       state;
  logic              idle, begin_fetch, chain_end, fetch_last, fetch_allow;
  logic              fw_we;
  logic [WIDX_W-1:0] fw_idx;
  logic [31:0]       fw_data;
  logic [31:0]       link, ctrl;

  assign fetch_allow = (state == ST_FETCH) && ctrl[CTRL_EN_BIT];
  assign mv_ctrl     = ctrl;
  assign cur_link    = link;

  lldf_regs #(.CNT_W(CNT_W), .STEP_BYTES(STEP_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_we), .host_sel(reg_sel), .host_wdata(reg_wdata),
    .idle(idle), .fw_we(fw_we), .fw_idx(fw_idx), .fw_data(fw_data),
    .step(mv_step), .chain_end(chain_end),
    .link(link), .cnt(cur_count), .src(mv_src), .dst(mv_dst), .ctrl(ctrl)
  );

  lldf_fetch u_fetch (
    .clk(clk), .rst_n(rst_n),
    .begin_fetch(begin_fetch), .link(link), .allow(fetch_allow),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .fw_we(fw_we), .fw_idx(fw_idx), .fw_data(fw_data), .fetch_last(fetch_last)
  );

  lldf_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_we), .host_sel(reg_sel), .host_en_bit(reg_wdata[CTRL_EN_BIT]),
    .enable(ctrl[CTRL_EN_BIT]), .node_flag(ctrl[CTRL_NODE_BIT]), .link(link),
    .mv_done(mv_done), .fetch_last(fetch_last),
    .state(state), .mv_start(mv_start), .begin_fetch(begin_fetch),
    .chain_end(chain_end), .node_irq(node_irq), .chain_irq(chain_irq),
    .busy(busy), .idle(idle)
  );

  // R8
  paused_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

// File: tb/lldf_top_bench.sv
`timescale 1ns/1ps
module lldf_top_bench;
  localparam int CNT_W = 16;
  localparam int STEP  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic mv_start, mv_done = 1'b0, mv_step = 1'b0;
  logic [31:0] mv_src, mv_dst, mv_ctrl, cur_link;
  logic node_irq, chain_irq, busy;
  logic [CNT_W-1:0] cur_count;

  always #2 clk = ~clk;

  lldf_top #(.CNT_W(CNT_W), .STEP_BYTES(STEP)) u_lldf_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_ctrl(mv_ctrl),
    .mv_done(mv_done), .mv_step(mv_step), .node_irq(node_irq), .chain_irq(chain_irq),
    .busy(busy), .cur_link(cur_link), .cur_count(cur_count)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:31];
  logic [31:0] src_log [0:7];
  int reads = 0, starts = 0, node_cnt = 0, chain_cnt = 0;
  int done_wait = 0;
  bit done_owed = 0, auto_done = 1;
  bit rd_pend = 0;
  logic [31:0] rd_addr = '0;

  // Memory responder, mover model and event monitor, all on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      mv_done = 1'b0;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[rd_addr[9:2]];
        rd_pend = 0;
      end
      if (rst_n && mem_req) begin
        rd_pend = 1;
        rd_addr = mem_addr;
        rd_log[reads % 32] = mem_addr;
        reads++;
      end
      if (node_irq) node_cnt++;
      if (chain_irq) chain_cnt++;
      if (mv_start) begin
        src_log[starts % 8] = mv_src;
        starts++;
        done_wait = 3;
      end else if (done_wait > 0) begin
        done_wait--;
        if (done_wait == 0) done_owed = 1;
      end
      if (done_owed && auto_done) begin
        mv_done = 1'b1;
        done_owed = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] lnk, cnt, src, dst, ctrl);
    wr(3'd0, lnk); wr(3'd1, cnt); wr(3'd2, src); wr(3'd3, dst); wr(3'd4, ctrl);
  endtask

  task automatic wait_chain(input int c0, input string req);
    for (int i = 0; i < 400; i++) begin
      if (chain_cnt > c0) return;
      @(negedge clk);
    end
    chk(req, 32'(chain_cnt), 32'(c0 + 1));
  endtask

  task automatic put_desc(input int a, input logic [31:0] lnk, cnt, src, dst, ctrl);
    mem[a/4 + 0] = lnk;
    for (int k = 1; k < 4; k++) mem[a/4 + k] = 32'hDEAD_0000 + 32'(k);
    mem[a/4 + 4] = cnt; mem[a/4 + 5] = src; mem[a/4 + 6] = dst; mem[a/4 + 7] = ctrl;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mv_start", 32'(mv_start), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irqs", 32'({node_irq, chain_irq}), 0);
    chk("R1 cur_link", cur_link, 0);
    chk("R1 cur_count", 32'(cur_count), 0);
  endtask

  task automatic t_single();
    int r0 = reads, n0 = node_cnt, c0 = chain_cnt;
    load(32'h0, 32'h40, 32'h1000, 32'h2000, 32'h3);
    chk("R2 start", 32'(mv_start), 1);
    chk("R2 src", mv_src, 32'h1000);
    chk("R2 dst", mv_dst, 32'h2000);
    chk("R2 count", 32'(cur_count), 32'h40);
    chk("R2 busy", 32'(busy), 1);
    wait_chain(c0, "R5 chain event");
    @(negedge clk);
    chk("R5 no reads", 32'(reads - r0), 0);
    chk("R5 busy low", 32'(busy), 0);
    chk("R6 node event", 32'(node_cnt - n0), 1);
  endtask

  task automatic t_chain();
    int r0 = reads, s0 = starts, n0 = node_cnt, c0 = chain_cnt;
    put_desc(32'h100, 32'h146, 32'h20, 32'h3000, 32'h4000, 32'h2);
    put_desc(32'h140, 32'h0, 32'h10, 32'h5000, 32'h6000, 32'h0);
    load(32'h10E, 32'h8, 32'h1111, 32'h2222, 32'h1);
    wait_chain(c0, "R4 chain end");
    @(negedge clk);
    chk("R4 reads", 32'(reads - r0), 16);
    chk("R4 first addr", rd_log[r0 % 32], 32'h100);
    chk("R4 eighth addr", rd_log[(r0 + 7) % 32], 32'h11C);
    chk("R4 second node addr", rd_log[(r0 + 8) % 32], 32'h140);
    chk("R10 starts", 32'(starts - s0), 3);
    chk("R4 node2 src", src_log[(s0 + 1) % 8], 32'h3000);
    chk("R4 node3 src", src_log[(s0 + 2) % 8], 32'h5000);
    chk("R6 one flagged node", 32'(node_cnt - n0), 1);
    chk("R11 link at end", cur_link, 32'h0);
    chk("R4 last count", 32'(cur_count), 32'h10);
  endtask

  task automatic t_freeze();
    int n0 = node_cnt, c0 = chain_cnt;
    auto_done = 0;
    load(32'h0, 32'h30, 32'hA, 32'hB, 32'h1);
    wr(3'd2, 32'hFFFF);
    wr(3'd0, 32'h55);
    wr(3'd1, 32'h7);
    wr(3'd4, 32'h3);
    chk("R3 src kept", mv_src, 32'hA);
    chk("R3 link kept", cur_link, 32'h0);
    chk("R3 count kept", 32'(cur_count), 32'h30);
    chk("R3 ctrl only enable", mv_ctrl, 32'h1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); mv_step = 1'b1;
    end
    @(negedge clk); mv_step = 1'b0;
    chk("R9 step down", 32'(cur_count), 32'h30 - 2 * STEP);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); mv_step = 1'b1;
    end
    @(negedge clk); mv_step = 1'b0;
    chk("R9 saturate", 32'(cur_count), 0);
    @(posedge clk); auto_done = 1;
    wait_chain(c0, "R3 chain end");
    @(negedge clk);
    chk("R3 no node event", 32'(node_cnt - n0), 0);
  endtask

  task automatic t_pause();
    int r0, s0, c0 = chain_cnt;
    put_desc(32'h180, 32'h0, 32'h4, 32'h7000, 32'h7100, 32'h0);
    auto_done = 0;
    load(32'h182, 32'h4, 32'h6000, 32'h6100, 32'h1);
    r0 = reads; s0 = starts;
    wr(3'd4, 32'h0);
    chk("R8 busy drops", 32'(busy), 0);
    @(posedge clk); auto_done = 1;
    repeat (12) @(negedge clk);
    chk("R8 no reads", 32'(reads - r0), 0);
    chk("R8 no start", 32'(starts - s0), 0);
    chk("R8 no chain end", 32'(chain_cnt - c0), 0);
    wr(3'd4, 32'h1);
    chk("R8 busy again", 32'(busy), 1);
    wait_chain(c0, "R8 resume end");
    chk("R8 resumed reads", 32'(reads - r0), 8);
    chk("R8 resumed src", src_log[s0 % 8], 32'h7000);
  endtask

  task automatic t_cyclic();
    int s0 = starts, n0 = node_cnt, c0 = chain_cnt, s1;
    put_desc(32'h200, 32'h202, 32'h4, 32'h8000, 32'h8100, 32'h2);
    load(32'h202, 32'h4, 32'h8000, 32'h8100, 32'h1);
    for (int i = 0; i < 400; i++) begin
      if (starts - s0 >= 5) break;
      @(negedge clk);
    end
    chk("R7 laps", 32'(starts - s0 >= 5), 1);
    wr(3'd4, 32'h0);
    repeat (30) @(negedge clk);
    s1 = starts;
    repeat (30) @(negedge clk);
    chk("R7 stopped", 32'(starts), 32'(s1));
    chk("R7 no chain end", 32'(chain_cnt - c0), 0);
    chk("R7 busy low", 32'(busy), 0);
    chk("R7 node events", 32'(node_cnt - n0 >= 3), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_freeze();
    t_pause();
    t_cyclic();
    finish_run();
  end
endmodule